// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block is the sending half of an asynchronous serial channel, controlled through a simple register write port. It has two storage stages. A holding register takes a byte from the host. A separate shift register puts the previous byte out on the serial line. The block moves a byte from the holding stage into the shift stage by itself, so the host can queue the next character while the current one is still on the wire.

Two status bits are brought out. The ready flag shows that the holding stage is free. The empty flag shows that both stages are idle and the line has finished its last stop bit. Host writes are accepted only while the ready flag is high and the transmitter is enabled; any other write is dropped without effect. The line moves forward one bit for each pulse of a baud enable that comes from outside. Each character is framed as one low start bit, the data bits least-significant first, and one high stop bit.

Top module: `uart_tx_dbuf`

## Requirements
- R1: While reset is applied and right after it, `tx_rdy` = 1, `tx_emp` = 1 and `txd` = 1 (idle line).
- R2: A write (`wr_en` = 1) made while `tx_rdy` = 1 and `tx_enable` = 1 is accepted, and from the next cycle `tx_rdy` = 0 and `tx_emp` = 0.
- R3: A write made while `tx_rdy` = 0 or `tx_enable` = 0 is dropped. The held byte is unchanged, and the dropped byte never appears on `txd`.
- R4: On a `baud_tick` cycle where the shift stage is idle or sending its stop bit, the holding stage is full and `tx_enable` = 1, the held byte moves into the shift stage and `tx_rdy` returns to 1 on the next cycle.
- R5: A character on `txd` is one 0 start bit, then 8 data bits with bit 0 first, then one 1 stop bit. The line is 1 whenever no character is being sent.
- R6: `txd` changes only on the clock edge of a cycle where `baud_tick` = 1, and each bit lasts exactly one baud pulse.
- R7: A held byte begins its start bit on the baud pulse right after the previous stop bit, so consecutive start bits are exactly 10 baud pulses apart.
- R8: `tx_emp` = 1 exactly when the holding stage is empty and the shift stage is idle. It rises on the baud pulse that ends the last stop bit.
- R9: Clearing `tx_enable` during a character lets that character complete. A byte still held is not loaded until `tx_enable` is 1 again, and `tx_rdy` stays 0 in the meantime.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_data | input | 8 | Byte offered by the host |
| tx_enable | input | 1 | Transmitter enable |
| baud_tick | input | 1 | One pulse per serial bit time |
| txd | output | 1 | Serial output line, idles high |
| tx_rdy | output | 1 | Holding stage free; writes accepted |
| tx_emp | output | 1 | Both stages empty and line idle |

## Verification
The assertions assume that `baud_tick` is a single-cycle qualifier that may come at any rate, including on every cycle, and that `wr_en` may be raised at any time, including while writes are being refused. The stimulus covers a steady tick every fourth cycle, a tick on every cycle, an irregular tick pattern, and long stretches with no tick at all, so that refused writes are certain to meet a full holding stage. `tx_enable` is switched both while the line is idle and in the middle of a character.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic {
    SH_IDLE = 1'b0,
    SH_SEND = 1'b1
  } sh_state_t;

  // Number of line bits in one character: start + data + stop.
  function automatic int frame_len(input int data_w);
    return data_w + 2;
  endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_enable,
  input  logic              take,
  output logic              hold_valid,
  output logic [DATA_W-1:0] hold_data,
  output logic              accept
);

  // A write lands only when the slot is free and the channel is enabled.
  assign accept = wr_en & ~hold_valid & tx_enable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      hold_data  <= '0;
    end else if (accept) begin
      hold_valid <= 1'b1;
      hold_data  <= wr_data;
    end else if (take) begin
      hold_valid <= 1'b0;
    end
  end

  assert_accept_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> hold_valid);

  assert_drop_keeps_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !accept) |=> $stable(hold_data));

  assert_take_needs_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> hold_valid);

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              tx_enable,
  input  logic              hold_valid,
  input  logic [DATA_W-1:0] hold_data,
  output logic              take,
  output logic              busy,
  output logic              txd
);

  localparam int FRAME_W = frame_len(DATA_W);
  localparam int POS_W   = $clog2(FRAME_W);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_W - 1);

  sh_state_t          state;
  logic [FRAME_W-1:0] frame;
  logic [POS_W-1:0]   pos;
  logic               at_end;

  // Line image of a character, bit 0 goes out first.
  function automatic logic [FRAME_W-1:0] make_frame(input logic [DATA_W-1:0] d);
    return {1'b1, d, 1'b0};
  endfunction

  assign at_end = (state == SH_IDLE) || (pos == LAST_POS);
  assign take   = baud_tick & at_end & hold_valid & tx_enable;
  assign busy   = (state == SH_SEND);
  assign txd    = busy ? frame[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SH_IDLE;
      frame <= '1;
      pos   <= '0;
    end else if (baud_tick) begin
      if (take) begin
        state <= SH_SEND;
        frame <= make_frame(hold_data);
        pos   <= '0;
      end else if (state == SH_SEND) begin
        if (pos == LAST_POS) begin
          state <= SH_IDLE;
        end else begin
          pos   <= pos + 1'b1;
          frame <= {1'b1, frame[FRAME_W-1:1]};
        end
      end
    end
  end

  assert_line_moves_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(txd));

  assert_start_bit_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !txd);

endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_enable,
  input  logic              baud_tick,
  output logic              txd,
  output logic              tx_rdy,
  output logic              tx_emp
);

  logic              hold_valid;
  logic [DATA_W-1:0] hold_data;
  logic              accept;
  logic              take;
  logic              shift_busy;

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .tx_enable  (tx_enable),
    .take       (take),
    .hold_valid (hold_valid),
    .hold_data  (hold_data),
    .accept     (accept)
  );

  uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .tx_enable  (tx_enable),
    .hold_valid (hold_valid),
    .hold_data  (hold_data),
    .take       (take),
    .busy       (shift_busy),
    .txd        (txd)
  );

  assign tx_rdy = ~hold_valid;
  assign tx_emp = ~hold_valid & ~shift_busy;

  assert_take_frees_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> tx_rdy);

  assert_empty_line_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_emp |-> txd);

  assert_disabled_stays_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_enable && !shift_busy) |=> !shift_busy);

  assert_accept_clears_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!tx_rdy && !tx_emp));

endmodule

// File: tb/sim_uart_tx_dbuf.sv
`timescale 1ns/1ps
module sim_uart_tx_dbuf;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       tx_enable;
  logic       baud_tick;
  logic       txd, tx_rdy, tx_emp;

  always #10 clk = ~clk;

  uart_tx_dbuf u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tx_enable(tx_enable), .baud_tick(baud_tick),
    .txd(txd), .tx_rdy(tx_rdy), .tx_emp(tx_emp)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int m_hold;        // -1 when the slot is empty
  bit m_q[$];        // line bits still to go, front is on the wire
  bit prev_tick;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hold = -1;
      m_q.delete();
      prev_tick = 0;
    end else begin
      bit acc, ld;
      acc = wr_en && (m_hold < 0) && tx_enable;
      ld  = baud_tick && (m_q.size() <= 1) && (m_hold >= 0) && tx_enable;
      if (baud_tick) begin
        if (ld) begin
          m_q.delete();
          m_q.push_back(1'b0);
          for (int i = 0; i < 8; i++) m_q.push_back(m_hold[i]);
          m_q.push_back(1'b1);
          m_hold = -1;
        end else if (m_q.size() > 0) begin
          void'(m_q.pop_front());
        end
      end
      if (acc) m_hold = int'(wr_data);
      prev_tick = baud_tick;
    end
  end

  // ---------------- per-cycle compare and line decoder ----------------
  int     dstate = -1;
  logic [7:0] dbyte;
  byte    rx_q[$];
  int     tk = 0;
  int     start_tk[$];

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_txd;
      e_txd = (m_q.size() > 0) ? m_q[0] : 1'b1;
      chk(txd === e_txd, "R5", "txd vs model", int'(txd), int'(e_txd));
      chk(tx_rdy === (m_hold < 0), "R4", "tx_rdy vs model", int'(tx_rdy), int'(m_hold < 0));
      chk(tx_emp === ((m_hold < 0) && m_q.size() == 0), "R8", "tx_emp vs model",
          int'(tx_emp), int'((m_hold < 0) && m_q.size() == 0));
      if (prev_tick) begin
        tk++;
        if (dstate < 0) begin
          if (txd == 1'b0) begin
            dstate = 0;
            start_tk.push_back(tk);
          end
        end else if (dstate < 8) begin
          dbyte[dstate] = txd;
          dstate++;
        end else begin
          chk(txd === 1'b1, "R5", "stop bit", int'(txd), 1);
          rx_q.push_back(dbyte);
          dstate = -1;
        end
      end
    end
  end

  // ---------------- baud tick generator ----------------
  int tick_mode = 0;   // 0: every 4th, 1: irregular, 2: every cycle, 3: none
  int tick_cnt = 0;
  always @(negedge clk) begin
    tick_cnt++;
    case (tick_mode)
      0:       baud_tick <= (tick_cnt % 4 == 0);
      1:       baud_tick <= ($urandom % 3 == 0);
      2:       baud_tick <= 1'b1;
      default: baud_tick <= 1'b0;
    endcase
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic write_now(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (!tx_rdy) @(negedge clk);
    wr_en = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_empty();
    int n = 0;
    @(negedge clk);
    while (!(tx_emp && dstate < 0) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_rx(input string req, input byte exp[$]);
    chk(rx_q.size() == exp.size(), req, "received count", rx_q.size(), exp.size());
    for (int i = 0; i < exp.size() && i < rx_q.size(); i++)
      chk(rx_q[i] == exp[i], req, "received byte", int'(rx_q[i]) & 255, int'(exp[i]) & 255);
    rx_q.delete();
  endtask

  // ---------------- test sequence ----------------
  initial begin
    byte exp_b[$];
    rst_n = 1'b0;
    wr_en = 1'b0;
    wr_data = 8'h00;
    tx_enable = 1'b1;
    baud_tick = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(tx_rdy === 1'b1, "R1", "tx_rdy in reset", int'(tx_rdy), 1);
    chk(tx_emp === 1'b1, "R1", "tx_emp in reset", int'(tx_emp), 1);
    chk(txd === 1'b1, "R1", "txd in reset", int'(txd), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_rdy === 1'b1 && tx_emp === 1'b1 && txd === 1'b1, "R1", "state after reset",
        int'({tx_rdy, tx_emp, txd}), 7);

    // R2 / R3: accepted write, then a write refused because the slot is full
    tick_mode = 3;
    repeat (2) @(negedge clk);
    write_now(8'hA5);
    chk(tx_rdy === 1'b0, "R2", "tx_rdy after write", int'(tx_rdy), 0);
    chk(tx_emp === 1'b0, "R2", "tx_emp after write", int'(tx_emp), 0);
    write_now(8'h11);
    chk(tx_rdy === 1'b0, "R3", "tx_rdy after refused write", int'(tx_rdy), 0);
    tick_mode = 0;
    wait_empty();
    exp_b = '{8'hA5};
    check_rx("R3", exp_b);

    // R3: write while disabled is dropped
    tx_enable = 1'b0;
    write_now(8'h3C);
    chk(tx_rdy === 1'b1 && tx_emp === 1'b1, "R3", "flags after disabled write",
        int'({tx_rdy, tx_emp}), 3);
    repeat (60) @(negedge clk);
    chk(txd === 1'b1, "R3", "line idle after disabled write", int'(txd), 1);
    tx_enable = 1'b1;
    exp_b = '{};
    check_rx("R3", exp_b);

    // R7: back-to-back characters, start bits 10 ticks apart
    start_tk.delete();
    send(8'h01); send(8'h80); send(8'hFF); send(8'h00);
    wait_empty();
    exp_b = '{8'h01, 8'h80, 8'hFF, 8'h00};
    check_rx("R7", exp_b);
    for (int i = 1; i < start_tk.size(); i++)
      chk(start_tk[i] - start_tk[i-1] == 10, "R7", "ticks between starts",
          start_tk[i] - start_tk[i-1], 10);

    // R6: a tick on every cycle
    tick_mode = 2;
    send(8'h5A); send(8'hC3);
    wait_empty();
    exp_b = '{8'h5A, 8'hC3};
    check_rx("R6", exp_b);
    tick_mode = 0;

    // R9: enable removed mid-character
    send(8'h55); send(8'h66);
    while (dstate != 3) @(negedge clk);
    tx_enable = 1'b0;
    repeat (200) @(negedge clk);
    chk(tx_rdy === 1'b0, "R9", "held byte kept while disabled", int'(tx_rdy), 0);
    chk(txd === 1'b1, "R9", "line idle while disabled", int'(txd), 1);
    exp_b = '{8'h55};
    check_rx("R9", exp_b);
    tx_enable = 1'b1;
    wait_empty();
    exp_b = '{8'h66};
    check_rx("R9", exp_b);

    // R6 / R5: irregular ticks with mixed data
    tick_mode = 1;
    exp_b = '{};
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      exp_b.push_back(b);
      send(b);
    end
    wait_empty();
    check_rx("R5", exp_b);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule